// File: doc/BRIEF.md
# Configurable Serial Audio Input Receiver

This block turns a serial audio stream (bit clock, word clock and one or more data lines) into parallel signed samples. The external clocks are oversampled by the much faster system clock. The block synchronises them and picks out the bit-clock edge on which data is stable. A position counter, re-armed by the word clock, tells it when a complete sample has been shifted in.

A small control register selects the framing. The stereo framings are I2S, left-justified, and right-justified at 24, 20, 18 or 16 bits. The eight-slot TDM framing uses 32-bit slots. Bit-clock polarity and word-clock polarity are set independently. In TDM mode the word-clock polarity picks the edge that opens a frame, so a 50% word clock and a one-bit frame pulse both work. For each captured channel the block raises a one-cycle strobe and presents the sample of every data line together with a channel index.

Top module: `aud_serin_rx`

## Requirements
- R1: The control register resets to 0x00. A write stores bits 4:0 of the written byte. Bits 7:5 always read as zero. Bit 4 is the word-clock polarity, bit 3 is the bit-clock polarity, and bits 2:0 are the format code.
- R2: The format codes are: 0 = I2S, 1 = left-justified, 2 = TDM, 3/4/5/6 = right-justified 24/20/18/16 bits, and 7 = reserved.
- R3: With bit-clock polarity 0, data and word clock are sampled on rising bit-clock edges. With polarity 1 they are sampled on falling edges.
- R4: In stereo formats the channel index is 0 (left) while the word clock equals the word-clock polarity bit, and 1 otherwise. Left-justified and right-justified sources, which put left in the high phase, therefore use polarity 1.
- R5: In I2S, each half-frame's sample is the 24 bits that start one bit after the word-clock change, MSB first.
- R6: In left-justified format, the 24-bit sample starts MSB first on the first bit of the half-frame.
- R7: In right-justified formats the sample's LSB is bit 31 of the 32-bit half-frame. Samples narrower than 24 bits are sign-extended to 24.
- R8: In TDM, a frame opens on a word-clock falling edge (polarity 0) or rising edge (polarity 1). Slot s covers frame bits 32s..32s+31 and is reported as channel s. Its 24-bit sample starts MSB first at bit 32s+1.
- R9: In TDM, a one-bit-wide word-clock pulse (low for polarity 0, high for polarity 1) frames the data exactly as a 50% word clock does.
- R10: In TDM, only data line 0 is used. The sample fields of all other lines are zero when the strobe is high.
- R11: With the reserved format code, no strobe is produced.
- R12: The strobe lasts one system clock. Sample and channel outputs hold between strobes and are zero after reset. No strobe appears until a framing word-clock edge has been seen after reset.

Ports table below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we_i | input | 1 | Control register write enable |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register contents |
| sclk_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word clock or frame pulse |
| sd_i | input | LANES | Serial data lines |
| valid_o | output | 1 | One-cycle sample strobe |
| chan_o | output | CH_W | Channel index of the strobed sample |
| sample_o | output | LANES*SAMPLE_W | Signed samples, line k at bits k*SAMPLE_W upward |

## Verification
A wrong bit position or frame-start decision shows at the ports the next time a sample completes: the value is shifted by one bit, or the strobe lands in the wrong half-frame. The delay is at most one half-frame in stereo modes and one slot in TDM. A stale channel or lock state shows as a swapped channel index or a strobe where none may appear. The bench therefore fills every bit outside a sample window with random data and compares each strobe against its expected value in order. A missing or extra strobe is reported at once, or when a run ends with expected values still queued.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [2:0] {
    FMT_I2S  = 3'd0,
    FMT_LJ   = 3'd1,
    FMT_TDM  = 3'd2,
    FMT_RJ24 = 3'd3,
    FMT_RJ20 = 3'd4,
    FMT_RJ18 = 3'd5,
    FMT_RJ16 = 3'd6,
    FMT_RSVD = 3'd7
  } fmt_e;

  typedef struct packed {
    logic ws_pol;
    logic bit_pol;
    fmt_e fmt;
  } ctrl_t;

  // significant bits carried by a format
  function automatic int unsigned fmt_bits(fmt_e f);
    case (f)
      FMT_RJ20: return 20;
      FMT_RJ18: return 18;
      FMT_RJ16: return 16;
      default:  return 24;
    endcase
  endfunction

endpackage

// File: rtl/aud_rx_pinsync.sv
module aud_rx_pinsync #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_pol_i,
  input  logic             sclk_i,
  input  logic             ws_i,
  input  logic [LANES-1:0] sd_i,
  output logic             cap_o,
  output logic             ws_o,
  output logic [LANES-1:0] sd_o
);
  localparam int NPINS = LANES + 2;

  logic [NPINS-1:0] raw, synced;
  logic             sclk_d;

  assign raw = {sd_i, ws_i, sclk_i};

  for (genvar i = 0; i < NPINS; i++) begin : g_sync
    logic [1:0] st;
    always_ff @(posedge clk) begin
      if (rst) st <= '0;
      else     st <= {st[0], raw[i]};
    end
    assign synced[i] = st[1];
  end

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= synced[0];
  end

  // capture edge: rising edge of the bit clock after polarity correction
  assign cap_o = (synced[0] ^ bit_pol_i) & ~(sclk_d ^ bit_pol_i);
  assign ws_o  = synced[1];
  assign sd_o  = synced[NPINS-1:2];

endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32,
  parameter int TDM_SLOTS = 8,
  parameter int CH_W      = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_i,
  input  logic            ws_i,
  input  ctrl_t           ctrl_i,
  output logic            hit_o,
  output logic [CH_W-1:0] chan_o
);
  localparam int FRAME_BITS = SLOT_BITS * TDM_SLOTS;
  localparam int SLOT_LOG   = $clog2(SLOT_BITS);
  localparam int POS_W      = $clog2(FRAME_BITS) + 1;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_q, pos_n, tgt;
  logic             ws_prev_q, primed_q, locked_q;
  logic             is_tdm, boundary, lock_n;

  always_comb begin
    is_tdm   = (ctrl_i.fmt == FMT_TDM);
    boundary = primed_q && (ws_i != ws_prev_q) &&
               (!is_tdm || (ws_i == ctrl_i.ws_pol));
    if (boundary)              pos_n = '0;
    else if (pos_q == POS_MAX) pos_n = pos_q;
    else                       pos_n = pos_q + 1'b1;
    lock_n = locked_q | boundary;

    case (ctrl_i.fmt)
      FMT_I2S: tgt = POS_W'(SAMPLE_W);
      FMT_LJ:  tgt = POS_W'(SAMPLE_W - 1);
      default: tgt = POS_W'(SLOT_BITS - 1);
    endcase

    hit_o = 1'b0;
    if (cap_i && lock_n && ctrl_i.fmt != FMT_RSVD) begin
      if (is_tdm)
        hit_o = (pos_n < POS_W'(FRAME_BITS)) &&
                (pos_n[SLOT_LOG-1:0] == SLOT_LOG'(SAMPLE_W));
      else
        hit_o = (pos_n == tgt);
    end

    if (is_tdm) chan_o = pos_n[SLOT_LOG +: CH_W];
    else        chan_o = CH_W'(ws_i ^ ctrl_i.ws_pol);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      ws_prev_q <= 1'b0;
      primed_q  <= 1'b0;
      locked_q  <= 1'b0;
    end else if (cap_i) begin
      ws_prev_q <= ws_i;
      if (!primed_q) begin
        primed_q <= 1'b1;
      end else begin
        pos_q    <= pos_n;
        locked_q <= lock_n;
      end
    end
  end

endmodule

// File: rtl/aud_rx_lane.sv
module aud_rx_lane
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_i,
  input  logic                sd_i,
  input  fmt_e                fmt_i,
  output logic [SAMPLE_W-1:0] word_o
);
  logic [SAMPLE_W-2:0]        sr_q;
  logic [SAMPLE_W-1:0]        raw;
  logic signed [SAMPLE_W-1:0] tmp;
  int unsigned                w, sh;

  assign raw = {sr_q, sd_i};

  always_ff @(posedge clk) begin
    if (rst)        sr_q <= '0;
    else if (cap_i) sr_q <= raw[SAMPLE_W-2:0];
  end

  // keep the newest fmt_bits() bits and sign-extend them
  always_comb begin
    w      = fmt_bits(fmt_i);
    sh     = (w >= SAMPLE_W) ? 0 : SAMPLE_W - w;
    tmp    = raw << sh;
    word_o = tmp >>> sh;
  end

endmodule

// File: rtl/aud_serin_rx.sv
module aud_serin_rx
  import aud_rx_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32,
  parameter int TDM_SLOTS = 8,
  parameter int CH_W      = $clog2(TDM_SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ctrl_we_i,
  input  logic [7:0]                ctrl_wdata_i,
  output logic [7:0]                ctrl_rdata_o,
  input  logic                      sclk_i,
  input  logic                      ws_i,
  input  logic [LANES-1:0]          sd_i,
  output logic                      valid_o,
  output logic [CH_W-1:0]           chan_o,
  output logic [LANES*SAMPLE_W-1:0] sample_o
);
  ctrl_t             ctrl_q;
  logic              cap, ws_s, hit;
  logic [LANES-1:0]  sd_s;
  logic [CH_W-1:0]   chan_w;
  logic [SAMPLE_W-1:0] word_w [LANES];
  logic [SAMPLE_W-1:0] samp_q [LANES];
  logic              unused_hi;

  assign unused_hi = ^ctrl_wdata_i[7:5];

  always_ff @(posedge clk) begin
    if (rst)            ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_t'(ctrl_wdata_i[4:0]);
  end
  assign ctrl_rdata_o = {3'b000, ctrl_q};

  aud_rx_pinsync #(.LANES(LANES)) sync_i (
    .clk(clk), .rst(rst), .bit_pol_i(ctrl_q.bit_pol),
    .sclk_i(sclk_i), .ws_i(ws_i), .sd_i(sd_i),
    .cap_o(cap), .ws_o(ws_s), .sd_o(sd_s)
  );

  aud_rx_framer #(
    .SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS),
    .TDM_SLOTS(TDM_SLOTS), .CH_W(CH_W)
  ) framer_i (
    .clk(clk), .rst(rst), .cap_i(cap), .ws_i(ws_s), .ctrl_i(ctrl_q),
    .hit_o(hit), .chan_o(chan_w)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    aud_rx_lane #(.SAMPLE_W(SAMPLE_W)) lane_i (
      .clk(clk), .rst(rst), .cap_i(cap), .sd_i(sd_s[k]),
      .fmt_i(ctrl_q.fmt), .word_o(word_w[k])
    );

    always_ff @(posedge clk) begin
      if (rst)
        samp_q[k] <= '0;
      else if (hit)
        samp_q[k] <= (k != 0 && ctrl_q.fmt == FMT_TDM) ? '0 : word_w[k];
    end
    assign sample_o[k*SAMPLE_W +: SAMPLE_W] = samp_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      chan_o  <= '0;
    end else begin
      valid_o <= hit;
      if (hit) chan_o <= chan_w;
    end
  end

endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk #(
  parameter int LANES    = 2,
  parameter int SAMPLE_W = 24,
  parameter int CH_W     = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      ctrl_we_i,
  input logic [7:0]                ctrl_wdata_i,
  input logic [7:0]                ctrl_rdata_o,
  input logic                      valid_o,
  input logic [CH_W-1:0]           chan_o,
  input logic [LANES*SAMPLE_W-1:0] sample_o
);
  // R1
  ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_we_i |=> ctrl_rdata_o == {3'b000, $past(ctrl_wdata_i[4:0])});

  // R11
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rdata_o[2:0] == 3'b111) |=> !valid_o);

  // R4
  stereo_chan_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(ctrl_rdata_o[2:0]) != 3'b010) |-> (chan_o <= CH_W'(1)));

  // R12
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R12
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(sample_o) && $stable(chan_o)));

  if (LANES > 1) begin : g_lanes
    // R10
    tdm_lane_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_o && $past(ctrl_rdata_o[2:0]) == 3'b010)
        |-> (sample_o[LANES*SAMPLE_W-1:SAMPLE_W] == '0));
  end

endmodule

bind aud_serin_rx aud_rx_chk #(
  .LANES(LANES), .SAMPLE_W(SAMPLE_W), .CH_W(CH_W)
) chk_i (
  .clk(clk), .rst(rst), .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
  .ctrl_rdata_o(ctrl_rdata_o), .valid_o(valid_o), .chan_o(chan_o),
  .sample_o(sample_o)
);

// File: tb/aud_serin_rx_tb_top.sv
module aud_serin_rx_tb_top;
  localparam int LANES = 2;
  localparam int SW    = 24;
  localparam int CH_W  = 3;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                ctrl_we = 1'b0;
  logic [7:0]          ctrl_wdata = '0;
  logic [7:0]          ctrl_rdata;
  logic                sclk = 1'b0, ws = 1'b0;
  logic [LANES-1:0]    sd = '0;
  logic                valid;
  logic [CH_W-1:0]     chan;
  logic [LANES*SW-1:0] sample;

  always #4 clk = ~clk;

  aud_serin_rx dut_i (
    .clk(clk), .rst(rst), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .ctrl_rdata_o(ctrl_rdata), .sclk_i(sclk), .ws_i(ws), .sd_i(sd),
    .valid_o(valid), .chan_o(chan), .sample_o(sample)
  );

  typedef struct {
    logic [CH_W-1:0]     ch;
    logic [LANES*SW-1:0] smp;
    string               req;
  } exp_t;

  exp_t  exp_q[$];
  int    n_run = 0, n_fail = 0, n_valid = 0;
  logic  ibp_cur = 1'b0;
  string cur_req = "R12";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (!rst && valid) begin
      n_valid++;
      if (exp_q.size() == 0) begin
        check(1'b0, cur_req, "unexpected strobe", 64'(sample), 64'(0));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(chan == e.ch, e.req, "channel", 64'(chan), 64'(e.ch));
        check(sample == e.smp, e.req, "sample", 64'(sample), 64'(e.smp));
      end
    end
  end

  task automatic start_run(input logic [7:0] c, input logic ws_idle);
    rst = 1'b1; ibp_cur = c[3]; sclk = c[3]; ws = ws_idle; sd = '0;
    exp_q.delete();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = c;
    @(negedge clk);
    ctrl_we = 1'b0;
    @(negedge clk);
    n_valid = 0;
  endtask

  // launch edge changes data, capture edge follows half a bit later
  task automatic send_bit(input logic w, input logic [LANES-1:0] d);
    sclk = ibp_cur; ws = w; sd = d;
    repeat (4) @(negedge clk);
    sclk = ~ibp_cur;
    repeat (4) @(negedge clk);
  endtask

  function automatic int unsigned width_of(input logic [2:0] f);
    case (f)
      3'd4: return 20;
      3'd5: return 18;
      3'd6: return 16;
      default: return 24;
    endcase
  endfunction

  function automatic logic [SW-1:0] sext(input int unsigned raw, input int unsigned w);
    int v;
    v = int'(raw);
    if (raw >= (32'd1 << (w - 1))) v = v - (1 << w);
    return v[SW-1:0];
  endfunction

  task automatic stereo_run(input logic [2:0] f, input logic ilp, input logic ibp,
                            input int halves, input string req);
    int unsigned w, start;
    logic ws0;
    ws0 = 1'b0;
    cur_req = req;
    w = width_of(f);
    start = (f == 3'd0) ? 1 : (f == 3'd1 || f == 3'd7) ? 0 : 32 - w;
    start_run({3'b000, ilp, ibp, f}, ~ws0);
    send_bit(~ws0, LANES'($urandom));
    for (int h = 0; h < halves; h++) begin
      int unsigned raw [LANES];
      logic wl;
      exp_t e;
      wl = ws0 ^ h[0];
      e.ch = CH_W'(wl ^ ilp);
      e.req = req;
      for (int k = 0; k < LANES; k++) begin
        raw[k] = $urandom & ((32'd1 << w) - 1);
        e.smp[k*SW +: SW] = sext(raw[k], w);
      end
      if (f != 3'd7) exp_q.push_back(e);
      for (int p = 0; p < 32; p++) begin
        logic [LANES-1:0] d;
        for (int k = 0; k < LANES; k++) begin
          if (p >= int'(start) && p < int'(start + w))
            d[k] = raw[k][int'(w) - 1 - (p - int'(start))];
          else
            d[k] = 1'($urandom);
        end
        send_bit(wl, d);
      end
    end
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, req, "strobes missing", 64'(exp_q.size()), 64'(0));
  endtask

  task automatic tdm_run(input logic ilp, input logic ibp, input logic pulse,
                         input int frames, input string req);
    cur_req = req;
    start_run({3'b000, ilp, ibp, 3'b010}, ~ilp);
    send_bit(~ilp, LANES'($urandom));
    for (int fr = 0; fr < frames; fr++) begin
      logic [SW-1:0] raw [8];
      for (int s = 0; s < 8; s++) begin
        exp_t e;
        raw[s] = SW'($urandom);
        e.ch = CH_W'(s);
        e.smp = '0;
        e.smp[SW-1:0] = raw[s];
        e.req = req;
        exp_q.push_back(e);
      end
      for (int p = 0; p < 256; p++) begin
        logic wl;
        logic [LANES-1:0] d;
        int o;
        o = p % 32;
        wl = pulse ? ((p == 0) ? ilp : ~ilp) : ((p < 128) ? ilp : ~ilp);
        d = LANES'($urandom);
        if (o >= 1 && o <= 24) d[0] = raw[p / 32][24 - o];
        send_bit(wl, d);
      end
    end
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, req, "strobes missing", 64'(exp_q.size()), 64'(0));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "R12", "watchdog expired", 64'(0), 64'(1));
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    // R12 / R1: reset state
    check(valid == 1'b0, "R12", "reset valid", 64'(valid), 64'(0));
    check(sample == '0, "R12", "reset sample", 64'(sample), 64'(0));
    check(chan == '0, "R12", "reset chan", 64'(chan), 64'(0));
    check(ctrl_rdata == 8'h00, "R1", "reset ctrl", 64'(ctrl_rdata), 64'(0));
    rst = 1'b0;
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = 8'hFF;
    @(negedge clk);
    ctrl_we = 1'b0;
    check(ctrl_rdata == 8'h1F, "R1", "ctrl upper bits", 64'(ctrl_rdata), 64'(8'h1F));

    // R12: no strobe without a framing edge
    start_run(8'h01, 1'b0);
    cur_req = "R12";
    for (int i = 0; i < 70; i++) send_bit(1'b0, LANES'($urandom));
    repeat (12) @(negedge clk);
    check(n_valid == 0, "R12", "strobes before lock", 64'(n_valid), 64'(0));

    stereo_run(3'd0, 1'b0, 1'b0, 6, "R5");     // I2S, R2 code 0
    stereo_run(3'd0, 1'b0, 1'b1, 6, "R3");     // falling-edge sampling
    stereo_run(3'd1, 1'b1, 1'b0, 6, "R6");     // left-justified, left in high phase
    stereo_run(3'd1, 1'b0, 1'b1, 4, "R4");     // swapped channel sense
    stereo_run(3'd3, 1'b1, 1'b0, 4, "R7");     // right-justified 24
    stereo_run(3'd4, 1'b1, 1'b0, 4, "R7");     // right-justified 20
    stereo_run(3'd5, 1'b1, 1'b1, 4, "R7");     // right-justified 18
    stereo_run(3'd6, 1'b1, 1'b0, 4, "R2");     // right-justified 16 code

    // R11: reserved format produces nothing
    stereo_run(3'd7, 1'b0, 1'b0, 4, "R11");
    check(n_valid == 0, "R11", "reserved strobes", 64'(n_valid), 64'(0));

    tdm_run(1'b0, 1'b0, 1'b0, 2, "R8+R10");   // falling-edge frame start
    tdm_run(1'b1, 1'b1, 1'b0, 2, "R8");       // rising-edge frame start
    tdm_run(1'b0, 1'b0, 1'b1, 2, "R9");       // low pulse
    tdm_run(1'b1, 1'b0, 1'b1, 1, "R9+R10");   // high pulse

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule